// File: doc/BRIEF.md
# SDRAM Refresh and Low-Power Scheduler

This block keeps track of the refresh obligation of a four-bank synchronous DRAM and drives the clock-enable pin for the low-power states. A free-running interval counter produces one refresh obligation per average refresh period. With the default parameters the period is 1562 cycles of a 100 MHz clock, which spreads 4096 row refreshes across 64 ms. Outstanding obligations are held in a saturating debt counter.

While debt is owed, the scheduler asks the memory arbiter, through a request/grant pair, for an all-bank precharge and then for an auto-refresh. The refresh uses an internally generated row address, so no address leaves this block. The arbiter may postpone a request for as long as it likes. When the debt reaches its ceiling, the urgency flag tells the arbiter that refresh now outranks every other command.

On request the scheduler also moves the device into self-refresh or power-down. Self-refresh is entered through a precharge and an entry command. After wake-up it holds off other traffic for a programmable recovery time and finishes with one auto-refresh. Power-down only drops clock-enable.

Top module: `sdram_refresh_sched`

## Requirements
- R1: During and right after reset: cke_o=1, cmd_req_o=0, cmd_o=0, hold_o=0, urgent_o=0, debt_o=0.
- R2: With the bench parameters, debt_o increases by one at clock edge n*TICK_CYCLES+1 after reset release (n>=1), counting edges from the first one with reset low. It saturates at MAX_DEBT, and a tick that finds the debt at MAX_DEBT is lost.
- R3: While idle with debt_o>0, the block requests cmd_o=1 (all-bank precharge), then after that grant requests cmd_o=2 (auto-refresh). Each granted auto-refresh lowers debt_o by one, never below zero. A tick and an auto-refresh grant in the same cycle leave debt_o unchanged.
- R4: Once cmd_req_o is high it stays high with cmd_o unchanged until the cycle in which cmd_grant_i is high.
- R5: urgent_o is high exactly while debt_o equals MAX_DEBT.
- R6: hold_o is high from the cycle after a precharge grant until the cycle after the matching auto-refresh or self-refresh entry grant. It is also high throughout self-refresh, power-down and recovery.
- R7: When sr_req_i is seen while idle, the block requests precharge and then cmd_o=3 (self-refresh entry). In the cycle after the entry grant, cke_o=0 and debt_o=0. No debt accrues while self-refresh lasts.
- R8: One cycle after sr_req_i is seen low in self-refresh, cke_o returns to 1 and hold_o stays 1. After max(recov_cycles_i,1) cycles an auto-refresh request (cmd_o=2) appears. hold_o falls the cycle after its grant.
- R9: With pd_req_i high, no debt and no sr_req_i, cke_o goes low with no command issued. It returns high when pd_req_i falls, when sr_req_i rises, or when debt_o reaches MAX_DEBT.
- R10: When sr_req_i and nonzero debt are both present at idle, self-refresh entry wins, and the entry grant clears the debt.
- R11: cmd_o encoding: 0 none, 1 precharge all banks, 2 auto-refresh, 3 self-refresh entry.
- R12: cmd_req_o is never high while cke_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sr_req_i | input | 1 | Level request to stay in self-refresh |
| pd_req_i | input | 1 | Level request to stay in power-down |
| recov_cycles_i | input | RECOV_W | Hold-off length after self-refresh exit |
| cmd_grant_i | input | 1 | Arbiter accepts the pending command this cycle |
| cmd_req_o | output | 1 | Command pending toward the arbiter |
| cmd_o | output | 2 | Pending command code (R11) |
| urgent_o | output | 1 | Refresh debt at ceiling, refresh takes priority |
| hold_o | output | 1 | Arbiter must issue no other commands |
| cke_o | output | 1 | Clock-enable to the device |
| debt_o | output | DEBT_W | Count of postponed refreshes |

## Verification
The interval tick and a refresh grant can land on the same clock edge, and so can the tick and a self-refresh entry grant. The stimulus table times the grant input so that an auto-refresh grant falls on edge 209, which is a tick edge, and a self-refresh entry grant falls on edge 241, also a tick edge. A reference model of the debt, built from the tick schedule and the observed grants, is compared against debt_o and urgent_o every cycle. The model expects an unchanged count in the first case and zero in the second.

// File: rtl/sdram_ref_pkg.sv
package sdram_ref_pkg;
  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_PREALL = 2'd1,
    CMD_AREF   = 2'd2,
    CMD_SRENT  = 2'd3
  } ref_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_REF, ST_SRENT, ST_SELF, ST_PDN, ST_RECOV, ST_RREF
  } ref_state_e;
endpackage

// File: rtl/sdram_ref_tick.sv
module sdram_ref_tick #(
  parameter int TICK_CYCLES = 1562
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= RELOAD;
      tick_o <= 1'b0;
    end else if (cnt_q == '0) begin
      cnt_q  <= RELOAD;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q - 1'b1;
      tick_o <= 1'b0;
    end
  end

  // R2: one obligation per interval, never two in a row
  a_r2_single_tick: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);
endmodule

// File: rtl/sdram_ref_debt.sv
module sdram_ref_debt #(
  parameter int MAX_DEBT = 8,
  parameter int DEBT_W   = $clog2(MAX_DEBT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              suspend_i,
  input  logic              dec_i,
  input  logic              clr_i,
  output logic [DEBT_W-1:0] debt_o,
  output logic              full_o
);
  localparam logic [DEBT_W-1:0] CEIL = DEBT_W'(MAX_DEBT);

  logic              inc, dec;
  logic [DEBT_W-1:0] debt_n;

  always_comb begin
    inc = tick_i && !suspend_i && (debt_o < CEIL);
    dec = dec_i && (debt_o != '0);
    if (clr_i) debt_n = '0;
    else       debt_n = debt_o + DEBT_W'(inc) - DEBT_W'(dec);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      debt_o <= '0;
      full_o <= 1'b0;
    end else begin
      debt_o <= debt_n;
      full_o <= (debt_n == CEIL);
    end
  end

  a_r2_debt_ceiling: assert property (@(posedge clk) disable iff (rst)
    debt_o <= CEIL);
  a_r7_clear_on_entry: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (debt_o == '0));
  a_r5_full_matches: assert property (@(posedge clk) disable iff (rst)
    full_o == (debt_o == CEIL));
endmodule

// File: rtl/sdram_ref_fsm.sv
module sdram_ref_fsm
  import sdram_ref_pkg::*;
#(
  parameter int RECOV_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sr_req_i,
  input  logic               pd_req_i,
  input  logic [RECOV_W-1:0] recov_i,
  input  logic               grant_i,
  input  logic               debt_nz_i,
  input  logic               urgent_i,
  output logic               cmd_req_o,
  output ref_cmd_e           cmd_o,
  output logic               hold_o,
  output logic               cke_o,
  output logic               suspend_o,
  output logic               dec_o,
  output logic               clr_o
);
  ref_state_e         state_q, state_n;
  logic               goal_sr_q, goal_sr_n;
  logic [RECOV_W-1:0] rcnt_q, rcnt_n;
  logic               granted;

  assign granted   = cmd_req_o && grant_i;
  assign dec_o     = granted && (cmd_o == CMD_AREF);
  assign clr_o     = granted && (cmd_o == CMD_SRENT);
  assign suspend_o = (state_q == ST_SELF);

  always_comb begin
    state_n   = state_q;
    goal_sr_n = goal_sr_q;
    rcnt_n    = rcnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (sr_req_i) begin
          state_n = ST_PRE; goal_sr_n = 1'b1;
        end else if (debt_nz_i) begin
          state_n = ST_PRE; goal_sr_n = 1'b0;
        end else if (pd_req_i) begin
          state_n = ST_PDN;
        end
      end
      ST_PRE:   if (granted) state_n = goal_sr_q ? ST_SRENT : ST_REF;
      ST_REF:   if (granted) state_n = ST_IDLE;
      ST_SRENT: if (granted) state_n = ST_SELF;
      ST_SELF: begin
        if (!sr_req_i) begin
          state_n = ST_RECOV; rcnt_n = recov_i;
        end
      end
      ST_RECOV: begin
        if (rcnt_q <= RECOV_W'(1)) state_n = ST_RREF;
        else                       rcnt_n  = rcnt_q - 1'b1;
      end
      ST_RREF:  if (granted) state_n = ST_IDLE;
      ST_PDN:   if (!pd_req_i || urgent_i || sr_req_i) state_n = ST_IDLE;
      default:  state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      goal_sr_q <= 1'b0;
      rcnt_q    <= '0;
      cmd_req_o <= 1'b0;
      cmd_o     <= CMD_NONE;
      hold_o    <= 1'b0;
      cke_o     <= 1'b1;
    end else begin
      state_q   <= state_n;
      goal_sr_q <= goal_sr_n;
      rcnt_q    <= rcnt_n;
      cmd_req_o <= state_n inside {ST_PRE, ST_REF, ST_SRENT, ST_RREF};
      unique case (state_n)
        ST_PRE:           cmd_o <= CMD_PREALL;
        ST_REF, ST_RREF:  cmd_o <= CMD_AREF;
        ST_SRENT:         cmd_o <= CMD_SRENT;
        default:          cmd_o <= CMD_NONE;
      endcase
      hold_o <= state_n inside {ST_REF, ST_SRENT, ST_SELF, ST_PDN, ST_RECOV, ST_RREF};
      cke_o  <= !(state_n inside {ST_SELF, ST_PDN});
    end
  end

  a_r4_request_held: assert property (@(posedge clk) disable iff (rst)
    (cmd_req_o && !grant_i) |=> (cmd_req_o && $stable(cmd_o)));
  a_r12_no_cmd_asleep: assert property (@(posedge clk) disable iff (rst)
    !(cmd_req_o && !cke_o));
  a_r7_cke_after_entry: assert property (@(posedge clk) disable iff (rst)
    (granted && cmd_o == CMD_SRENT) |=> !cke_o);
  a_r6_hold_asleep: assert property (@(posedge clk) disable iff (rst)
    !cke_o |-> hold_o);
  a_r8_wake_raises_cke: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SELF && !sr_req_i) |=> (cke_o && hold_o));
endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched
  import sdram_ref_pkg::*;
#(
  parameter int CLK_KHZ     = 100000,
  parameter int REFI_NS     = 15625,
  parameter int TICK_CYCLES = (CLK_KHZ * REFI_NS) / 1000000,
  parameter int MAX_DEBT    = 8,
  parameter int RECOV_W     = 8,
  parameter int DEBT_W      = $clog2(MAX_DEBT + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sr_req_i,
  input  logic               pd_req_i,
  input  logic [RECOV_W-1:0] recov_cycles_i,
  input  logic               cmd_grant_i,
  output logic               cmd_req_o,
  output logic [1:0]         cmd_o,
  output logic               urgent_o,
  output logic               hold_o,
  output logic               cke_o,
  output logic [DEBT_W-1:0]  debt_o
);
  logic     tick, suspend, dec, clr;
  ref_cmd_e cmd_w;

  sdram_ref_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk(clk), .rst(rst), .tick_o(tick));

  sdram_ref_debt #(.MAX_DEBT(MAX_DEBT), .DEBT_W(DEBT_W)) u_debt (
    .clk(clk), .rst(rst), .tick_i(tick), .suspend_i(suspend),
    .dec_i(dec), .clr_i(clr), .debt_o(debt_o), .full_o(urgent_o));

  sdram_ref_fsm #(.RECOV_W(RECOV_W)) u_fsm (
    .clk(clk), .rst(rst), .sr_req_i(sr_req_i), .pd_req_i(pd_req_i),
    .recov_i(recov_cycles_i), .grant_i(cmd_grant_i),
    .debt_nz_i(debt_o != '0), .urgent_i(urgent_o),
    .cmd_req_o(cmd_req_o), .cmd_o(cmd_w), .hold_o(hold_o), .cke_o(cke_o),
    .suspend_o(suspend), .dec_o(dec), .clr_o(clr));

  assign cmd_o = cmd_w;
endmodule

// File: tb/tb_sdram_refresh_sched.sv
`timescale 1ns/1ps
module tb_sdram_refresh_sched;
  localparam int TICK = 16;
  localparam int MAXD = 4;
  localparam int RW   = 4;
  localparam int DW   = $clog2(MAXD + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sr_req = 1'b0, pd_req = 1'b0, gnt = 1'b0;
  logic [RW-1:0] recov = RW'(5);
  logic cmd_req, urgent, hold, cke;
  logic [1:0] cmd;
  logic [DW-1:0] debt;

  always #5 clk = ~clk;

  sdram_refresh_sched #(.TICK_CYCLES(TICK), .MAX_DEBT(MAXD), .RECOV_W(RW)) dut (
    .clk(clk), .rst(rst), .sr_req_i(sr_req), .pd_req_i(pd_req),
    .recov_cycles_i(recov), .cmd_grant_i(gnt), .cmd_req_o(cmd_req),
    .cmd_o(cmd), .urgent_o(urgent), .hold_o(hold), .cke_o(cke), .debt_o(debt));

  int vectors = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  typedef struct packed {
    logic sr, pd, gnt;
    logic [7:0] len;
    logic cke, hold, req;
    logic [1:0] cmd;
    logic urg;
  } step_t;

  localparam int NSTEP = 15;
  localparam step_t STEPS [NSTEP] = '{
    '{1'b0,1'b0,1'b0, 8'd80, 1'b1,1'b0,1'b1, 2'd1, 1'b1},
    '{1'b0,1'b0,1'b1, 8'd14, 1'b1,1'b0,1'b0, 2'd0, 1'b0},
    '{1'b0,1'b1,1'b1, 8'd6,  1'b0,1'b1,1'b0, 2'd0, 1'b0},
    '{1'b0,1'b1,1'b0, 8'd70, 1'b1,1'b0,1'b1, 2'd1, 1'b1},
    '{1'b0,1'b0,1'b1, 8'd20, 1'b1,1'b0,1'b0, 2'd0, 1'b0},
    '{1'b0,1'b0,1'b0, 8'd17, 1'b1,1'b0,1'b1, 2'd1, 1'b0},
    '{1'b0,1'b0,1'b1, 8'd10, 1'b1,1'b0,1'b0, 2'd0, 1'b0},
    '{1'b1,1'b0,1'b0, 8'd22, 1'b1,1'b0,1'b1, 2'd1, 1'b0},
    '{1'b1,1'b0,1'b1, 8'd8,  1'b0,1'b1,1'b0, 2'd0, 1'b0},
    '{1'b1,1'b0,1'b1, 8'd40, 1'b0,1'b1,1'b0, 2'd0, 1'b0},
    '{1'b0,1'b0,1'b0, 8'd5,  1'b1,1'b1,1'b0, 2'd0, 1'b0},
    '{1'b0,1'b0,1'b0, 8'd1,  1'b1,1'b1,1'b1, 2'd2, 1'b0},
    '{1'b0,1'b0,1'b0, 8'd4,  1'b1,1'b1,1'b1, 2'd2, 1'b0},
    '{1'b0,1'b0,1'b1, 8'd6,  1'b1,1'b0,1'b0, 2'd0, 1'b0},
    '{1'b0,1'b1,1'b1, 8'd3,  1'b0,1'b1,1'b0, 2'd0, 1'b0}
  };

  function automatic string step_tag(input int i);
    case (i)
      0, 3:    return "R5 urgent at ceiling / R9 power-down exit";
      1, 4, 6: return "R3 refresh drain";
      2, 14:   return "R9 power-down entry";
      5:       return "R3 precharge requested";
      7:       return "R7 self-refresh precharge";
      8:       return "R10 self-refresh beats debt";
      9:       return "R7 self-refresh held";
      10, 11, 12: return "R8 recovery hold-off";
      default: return "R6 hold released";
    endcase
  endfunction

  // Reference debt model from R2/R3/R7: ticks at edges n*TICK+1.
  int cyc = 0, mdebt = 0;
  bit mself = 0, monitor_on = 0;
  always @(posedge clk) begin
    if (rst) begin
      cyc = 0; mdebt = 0; mself = 0;
    end else begin
      bit tk, inc, dec, sre;
      cyc++;
      tk  = (cyc > TICK) && ((cyc - 1) % TICK == 0);
      sre = cmd_req && gnt && (cmd == 2'd3);
      dec = cmd_req && gnt && (cmd == 2'd2) && (mdebt > 0);
      inc = tk && !mself && (mdebt < MAXD);
      if (sre) mdebt = 0;
      else     mdebt = mdebt + int'(inc) - int'(dec);
      if (sre) mself = 1;
      else if (mself && !sr_req) mself = 0;
    end
  end

  logic prev_req = 1'b0, prev_gnt = 1'b0;
  logic [1:0] prev_cmd = 2'd0;
  always @(negedge clk) begin
    if (monitor_on && !rst) begin
      chk("R2 debt count", int'(debt), mdebt);
      chk("R5 urgent flag", int'(urgent), int'(mdebt == MAXD));
      chk("R12 no request while cke low", int'(cmd_req && !cke), 0);
      if (prev_req && !prev_gnt) begin
        chk("R4 request held", int'(cmd_req), 1);
        chk("R4 command held", int'(cmd), int'(prev_cmd));
      end
    end
    prev_req = cmd_req; prev_gnt = gnt; prev_cmd = cmd;
  end

  task automatic check_reset_state(input string tag);
    chk({tag, " cke"}, int'(cke), 1);
    chk({tag, " req"}, int'(cmd_req), 0);
    chk({tag, " cmd"}, int'(cmd), 0);
    chk({tag, " hold"}, int'(hold), 0);
    chk({tag, " urgent"}, int'(urgent), 0);
    chk({tag, " debt"}, int'(debt), 0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_reset_state("R1 reset");
    rst = 1'b0;
    monitor_on = 1'b1;
    for (int i = 0; i < NSTEP; i++) begin
      sr_req = STEPS[i].sr;
      pd_req = STEPS[i].pd;
      gnt    = STEPS[i].gnt;
      repeat (int'(STEPS[i].len)) @(negedge clk);
      chk({step_tag(i), " cke"},    int'(cke),     int'(STEPS[i].cke));
      chk({step_tag(i), " hold R6"}, int'(hold),   int'(STEPS[i].hold));
      chk({step_tag(i), " req"},    int'(cmd_req), int'(STEPS[i].req));
      chk({step_tag(i), " cmd R11"}, int'(cmd),    int'(STEPS[i].cmd));
      chk({step_tag(i), " urgent"}, int'(urgent),  int'(STEPS[i].urg));
    end
    // Directed: reset taken while in power-down (R1)
    monitor_on = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check_reset_state("R1 reset from power-down");
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end
endmodule